// File: doc/BRIEF.md
# Daisy-Chain Bus Arbitration Cell

This block is one arbitration cell for a shared bus that has no central arbiter. Each bus module carries its own copy. The cells are strung together through a priority chain: a cell passes the chain signal on while it is not requesting, and blocks it while it is. Two shared open-collector lines connect all the cells, and each is modelled as a wired-AND. The first is a bus-request line, pulled low while anyone is asking for the bus. The second is a busy line, pulled low by whichever cell holds the bus. Each cell drives these lines only through a drive-low enable and reads back the resolved busy value.

A cell wins when its module is requesting and the chain reaching it is still high. The first cell has its chain input tied high, so it has the highest priority. A winning cell then waits for the busy line to read high. It pulls busy low, holds the bus until its module drops the request, and then lets busy float back high.

The cell has four registered states: idle, waiting for the chain, waiting for the bus to go free, and owning. Every transition depends only on the local request, the chain input and the sensed busy value. An owner is never pre-empted. A cell that already holds the bus keeps it even when a higher-priority cell starts to request.

Top module: `chain_arb_cell`

## Requirements
- R1: While `rst` is high at a clock edge, the cell enters idle. After that edge `bus_owned` and `busy_low` are 0.
- R2: `breq_low` is 1 in exactly the cycles where `req_i` is 1, with no clock delay.
- R3: `chain_out` is 0 whenever `req_i` is 1. Otherwise `chain_out` equals `chain_in`, in the same cycle.
- R4: `bus_owned` never rises at an edge where `chain_in` was 0 in the cycle before.
- R5: `bus_owned` rises only after a cycle in which `busy_sense` read 1.
- R6: `bus_owned` is 1 exactly when `busy_low` is 1.
- R7: An owning cell keeps `bus_owned` at 1 while `req_i` stays 1, whatever `chain_in` does.
- R8: When `req_i` is 0 at an edge, `bus_owned` is 0 after that edge, so the busy line is released.
- R9: A request withdrawn before ownership leaves the cell without ownership for as long as `req_i` stays 0.
- R10: An idle cell given `req_i`=1, `chain_in`=1 and `busy_sense`=1, all held steady, has `bus_owned`=1 after the second edge and 0 after the first.
- R11: In a chain with cell 0's `chain_in` tied to 1 and `chain_in[i]`=`chain_out[i-1]`, the requesting cell with the lowest index wins when the bus is free. No two cells own the bus in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Local module wants the bus |
| chain_in | input | 1 | Priority chain from the upstream cell (1 = no upstream requester) |
| chain_out | output | 1 | Priority chain to the downstream cell |
| breq_low | output | 1 | Drive-low enable for the shared bus-request line |
| busy_low | output | 1 | Drive-low enable for the shared busy line |
| busy_sense | input | 1 | Resolved value of the wired-AND busy line |
| bus_owned | output | 1 | This cell currently holds the bus |

## Verification
The chain output and the bus-request enable are combinational, so the bench checks them 1 ns after it drives the requests, before any edge. Ownership is registered and needs two edges from idle, one into the wait-for-free state and one into ownership. The bench therefore checks for no owner at the negative edge after the first rising edge and for the expected owner one cycle later. Release takes one edge, and a queued upstream cell takes ownership one edge after that, so hand-over checks sample at exactly those negative edges. The single-owner rule is checked at every negative edge of the whole run.

// File: rtl/chain_arb_pkg.sv
package chain_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_WAIT_CHAIN = 2'd1,
        ST_WAIT_BUSY  = 2'd2,
        ST_OWN        = 2'd3
    } arb_state_e;

    // Combinational view of one cell's chain stage.
    typedef struct packed {
        logic pass_on;   // value forwarded downstream
        logic pull_req;  // drive-low enable for the request line
        logic eligible;  // requesting and chain still open
    } chain_view_t;

    function automatic arb_state_e arb_next(
        input arb_state_e cur,
        input logic       want,
        input logic       chain_hi,
        input logic       bus_free
    );
        arb_state_e nxt;
        nxt = cur;
        unique case (cur)
            ST_IDLE: begin
                if (want) nxt = chain_hi ? ST_WAIT_BUSY : ST_WAIT_CHAIN;
            end
            ST_WAIT_CHAIN: begin
                if (!want)         nxt = ST_IDLE;
                else if (chain_hi) nxt = ST_WAIT_BUSY;
            end
            ST_WAIT_BUSY: begin
                if (!want)          nxt = ST_IDLE;
                else if (!chain_hi) nxt = ST_WAIT_CHAIN;
                else if (bus_free)  nxt = ST_OWN;
            end
            ST_OWN: begin
                if (!want) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/chain_arb_link.sv
module chain_arb_link
    import chain_arb_pkg::*;
(
    input  logic        want,
    input  logic        up_chain,
    output chain_view_t view
);
    always_comb begin
        view.pull_req = want;
        view.pass_on  = up_chain & ~want;
        view.eligible = up_chain & want;
    end
endmodule

// File: rtl/chain_arb_fsm.sv
module chain_arb_fsm
    import chain_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic want,
    input  logic chain_hi,
    input  logic bus_free,
    output logic holding
);
    arb_state_e state_q, state_d;

    always_comb state_d = arb_next(state_q, want, chain_hi, bus_free);

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign holding = (state_q == ST_OWN);

    // R10: an eligible waiter that sees a free bus claims it at the next edge
    assert_claim_on_free_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_BUSY && want && chain_hi && bus_free) |=> (state_q == ST_OWN));

    // R1: reset leaves the cell idle
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (state_q == ST_IDLE));
endmodule

// File: rtl/chain_arb_cell.sv
module chain_arb_cell
    import chain_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic chain_in,
    output logic chain_out,
    output logic breq_low,
    output logic busy_low,
    input  logic busy_sense,
    output logic bus_owned
);
    chain_view_t view;
    logic        holding;

    chain_arb_link link_i (
        .want     (req_i),
        .up_chain (chain_in),
        .view     (view)
    );

    chain_arb_fsm fsm_i (
        .clk      (clk),
        .rst      (rst),
        .want     (req_i),
        .chain_hi (chain_in),
        .bus_free (busy_sense),
        .holding  (holding)
    );

    assign chain_out = view.pass_on;
    assign breq_low  = view.pull_req;
    assign busy_low  = holding;
    assign bus_owned = holding;

    // R4: no win with a blocked chain
    assert_no_win_blocked_R4: assert property (@(posedge clk) disable iff (rst)
        (!bus_owned && !chain_in) |=> !bus_owned);

    // R5: ownership follows a free busy line
    assert_win_needs_free_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_owned) |-> $past(busy_sense));

    // R7: owner is never pre-empted while requesting
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_owned && req_i) |=> bus_owned);

    // R8: dropping the request releases the bus
    assert_release_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_owned && !req_i) |=> !bus_owned);

    // R9: no ownership after a cycle without a request
    assert_withdraw_R9: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> !bus_owned);

    // R11: an eligible cell is also the one whose chain was open
    assert_eligible_R11: assert property (@(posedge clk) disable iff (rst)
        view.eligible |-> !chain_out);
endmodule

// File: tb/chain_arb_cell_tb.sv
module chain_arb_cell_tb_top;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] req = '0;
    logic [N-1:0] chain_in, chain_out, breq_low, busy_low, owned;
    logic         busy_line;
    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    assign busy_line = ~|busy_low;
    assign chain_in  = {chain_out[N-2:0], 1'b1};

    for (genvar i = 0; i < N; i++) begin : g_node
        chain_arb_cell dut_i (
            .clk        (clk),
            .rst        (rst),
            .req_i      (req[i]),
            .chain_in   (chain_in[i]),
            .chain_out  (chain_out[i]),
            .breq_low   (breq_low[i]),
            .busy_low   (busy_low[i]),
            .busy_sense (busy_line),
            .bus_owned  (owned[i])
        );
    end

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    // R11 single-owner check on every cycle
    always @(negedge clk) begin
        if (!rst && !done) begin
            total++;
            if ($countones(owned) > 1) begin
                bad++;
                $display("FAIL R11 mutex act=%b exp=onehot0", owned);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] exp_own, exp_chain;
        repeat (3) @(negedge clk);
        chk("R1 reset owned", owned, '0);
        chk("R1 reset busy_low", busy_low, '0);
        rst = 1'b0;
        @(negedge clk);

        // sweep every nonzero request pattern from all-idle
        for (int p = 1; p < (1 << N); p++) begin
            req = p[N-1:0];
            #1;
            for (int i = 0; i < N; i++) exp_chain[i] = ~|(req & ((N'(1) << (i + 1)) - N'(1)));
            chk("R3 chain_out", chain_out, exp_chain);
            chk("R2 breq_low", breq_low, req);
            chk("R6 busy_low vs owned", busy_low, owned);
            @(negedge clk);
            chk("R10 no owner after first edge", owned, '0);
            @(negedge clk);
            exp_own = req & (~req + N'(1));
            chk("R11 lowest requester wins", owned, exp_own);
            chk("R10 owner after second edge", owned, exp_own);
            chk("R6 busy_low vs owned", busy_low, owned);
            req = '1;
            #1;
            for (int i = 0; i < N; i++) exp_chain[i] = 1'b0;
            chk("R3 chain blocked while requesting", chain_out, exp_chain);
            repeat (2) @(negedge clk);
            chk("R7 owner kept against higher request", owned, exp_own);
            req = '0;
            @(negedge clk);
            chk("R8 released after one edge", owned, '0);
            chk("R8 busy released", busy_low, '0);
            @(negedge clk);
        end

        // hand-over: cell 2 owns, cell 0 queues, cell 2 drops
        req = 4'b0100;
        repeat (2) @(negedge clk);
        chk("R11 cell 2 owns", owned, 4'b0100);
        req = 4'b0101;
        repeat (3) @(negedge clk);
        chk("R7 cell 2 keeps bus", owned, 4'b0100);
        req = 4'b0001;
        @(negedge clk);
        chk("R8 gap after release", owned, '0);
        @(negedge clk);
        chk("R5 queued cell claims freed bus", owned, 4'b0001);

        // withdrawal: cell 1 waits behind owner 0, then gives up
        req = 4'b0011;
        repeat (2) @(negedge clk);
        chk("R4 blocked cell 1 waits", owned, 4'b0001);
        req = 4'b0001;
        @(negedge clk);
        req = 4'b0000;
        repeat (3) @(negedge clk);
        chk("R9 withdrawn request never owns", owned, '0);

        // reset while owning
        req = 4'b1000;
        repeat (2) @(negedge clk);
        chk("R11 cell 3 owns alone", owned, 4'b1000);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset clears owner", owned, '0);
        req = '0;
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule